// File: doc/BRIEF.md
# Generation-Bit Event Queue Reader

This block pulls 32-bit event words out of a circular queue of 2^N entries held in a synchronous local memory. The queue has no shared head and tail pointers. The reader keeps only a read index and a one-bit generation toggle. A word counts as a fresh event when its top bit (bit 31) differs from that toggle. The producer writes each pass through the ring with the opposite generation value, so a slot left over from an earlier pass reads as stale.

A request has a peek/consume select. In both modes the block reads the slot at the current index. It answers with the 31-bit payload and a hit flag, or with zero when the slot holds no fresh event. Only a consume that finds an event moves the index on by one, wrapping modulo the queue size. The toggle inverts when the index wraps to zero. A queue-enable control gates the memory. When it is low, every request is answered with zero and the memory is never read.

The request and response sides are valid/ready streams. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` stays low from that point until the response has been taken. The response appears in the cycle after acceptance, because the memory has one cycle of read latency. It holds steady for as long as `rsp_ready` stays low. Reader state changes only on the cycle the response is taken.

Top module: `evq_toggle_reader`

## Requirements
- R1: After reset the index and the toggle are both zero, `req_ready` is 1 and `rsp_valid` is 0. A memory holding all zeros therefore answers a request with `rsp_hit`=0 and `rsp_data`=0.
- R2: When the addressed word has bit 31 unequal to the toggle, the response has `rsp_hit`=1 and `rsp_data` equal to word bits 30:0.
- R3: When the addressed word has bit 31 equal to the toggle, the response has `rsp_hit`=0 and `rsp_data`=0, and the next request reads the same index.
- R4: A consume request (`req_peek`=0) that hits moves the index to (index+1) mod 2^IDX_W, which appears on `mem_addr` for the next request.
- R5: When a consuming hit moves the index from 2^IDX_W-1 to 0, the toggle inverts, so words of the previous generation then read as empty.
- R6: A peek request (`req_peek`=1) returns the same result a consume would, but it changes neither the index nor the toggle.
- R7: While `q_enable` is 0 at acceptance, `mem_rd_en` stays low, the response is `rsp_hit`=0 with `rsp_data`=0, and no state changes.
- R8: `mem_rd_en` is raised only in the acceptance cycle, with `mem_addr` equal to the index. `rsp_valid` rises on the next cycle and, while `rsp_ready` is 0, it stays high with `rsp_data` and `rsp_hit` unchanged. `req_ready` stays 0 while a response is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| q_enable | input | 1 | Queue configured; 0 makes every read return zero |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Reader can take a request |
| req_peek | input | 1 | 1 = look without consuming, 0 = consume |
| mem_rd_en | output | 1 | Read strobe to the queue memory |
| mem_addr | output | IDX_W | Slot being read |
| mem_rdata | input | 32 | Word from the memory, valid one cycle after the strobe and held until the next strobe |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 31 | Event payload, or zero when empty |
| rsp_hit | output | 1 | A fresh event was found |

## Verification
The bench targets the generation boundary. After a full pass of the ring, slot zero still holds a word from the first generation. A reader that failed to invert its toggle on wrap would hand that stale word out again as a new event. Peeks are mixed with consumes at random, and the address of the following request is checked. A peek that advanced the index would show up there as a skipped event. Holding back `rsp_ready` for several cycles exposes any response that drifts or any state update made before the handshake. Reads with the queue disabled must return zero even when the memory holds a fresh word.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int WORD_W = 32;
  localparam int GEN_BIT = WORD_W - 1;
  localparam int PAY_W = WORD_W - 1;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [PAY_W-1:0] payload_t;
endpackage

// File: rtl/evq_index_ctrl.sv
module evq_index_ctrl #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [IDX_W-1:0] idx,
  output logic             tgl
);
  logic [IDX_W-1:0] idx_next;

  // Natural width truncation gives the size-minus-one mask.
  assign idx_next = idx + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
      tgl <= 1'b0;
    end else if (advance) begin
      idx <= idx_next;
      if (idx_next == '0) tgl <= ~tgl;
    end
  end
endmodule

// File: rtl/evq_entry_decode.sv
module evq_entry_decode
  import evq_pkg::*;
(
  input  word_t    word,
  input  logic     tgl,
  input  logic     enabled,
  output logic     hit,
  output payload_t payload
);
  assign hit = enabled && (word[GEN_BIT] != tgl);
  assign payload = hit ? word[PAY_W-1:0] : '0;
endmodule

// File: rtl/evq_toggle_reader.sv
module evq_toggle_reader
  import evq_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_enable,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_peek,
  output logic             mem_rd_en,
  output logic [IDX_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PAY_W-1:0] rsp_data,
  output logic             rsp_hit
);
  logic             busy_q;
  logic             peek_q;
  logic             en_q;
  logic             accept;
  logic             advance;
  logic             hit;
  logic [IDX_W-1:0] idx;
  logic             tgl;
  payload_t         payload;

  assign req_ready = !busy_q;
  assign accept    = req_valid && req_ready;
  assign mem_rd_en = accept && q_enable;
  assign mem_addr  = idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      peek_q <= 1'b0;
      en_q   <= 1'b0;
    end else if (accept) begin
      busy_q <= 1'b1;
      peek_q <= req_peek;
      en_q   <= q_enable;
    end else if (busy_q && rsp_ready) begin
      busy_q <= 1'b0;
    end
  end

  evq_entry_decode dec_i (
    .word    (mem_rdata),
    .tgl     (tgl),
    .enabled (en_q),
    .hit     (hit),
    .payload (payload)
  );

  assign rsp_valid = busy_q;
  assign rsp_hit   = busy_q && hit;
  assign rsp_data  = busy_q ? payload : '0;

  assign advance = busy_q && rsp_ready && hit && !peek_q;

  evq_index_ctrl #(.IDX_W(IDX_W)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (advance),
    .idx     (idx),
    .tgl     (tgl)
  );
endmodule

// File: rtl/evq_toggle_reader_chk.sv
module evq_toggle_reader_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             q_enable,
  input logic             req_valid,
  input logic             req_ready,
  input logic             mem_rd_en,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [30:0]      rsp_data,
  input logic             rsp_hit,
  input logic [IDX_W-1:0] idx,
  input logic             tgl,
  input logic             peek_q
);
  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_hit));
  // R8
  rd_then_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> rsp_valid);
  // R8
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready && !mem_rd_en);
  // R7
  rd_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> q_enable && req_valid);
  // R3
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_data == '0);
  // R6
  hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && (!rsp_hit || peek_q) |=> $stable(idx) && $stable(tgl));
  // R4
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && rsp_hit && !peek_q |=> idx == IDX_W'($past(idx) + 1'b1));
  // R5
  wrap_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && rsp_hit && !peek_q && (idx == '1) |=> tgl != $past(tgl));
endmodule

bind evq_toggle_reader evq_toggle_reader_chk #(.IDX_W(IDX_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .q_enable  (q_enable),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .mem_rd_en (mem_rd_en),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .rsp_hit   (rsp_hit),
  .idx       (idx),
  .tgl       (tgl),
  .peek_q    (peek_q)
);

// File: tb/evq_toggle_reader_tb.sv
module evq_toggle_reader_tb_top;
  localparam int IDX_W = 4;
  localparam int DEPTH = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic q_enable = 1'b1;
  logic req_valid = 1'b0;
  logic req_peek = 1'b0;
  logic rsp_ready = 1'b0;
  logic req_ready, mem_rd_en, rsp_valid, rsp_hit;
  logic [IDX_W-1:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic [30:0] rsp_data;

  logic [31:0] mem [DEPTH];

  int compared = 0;
  int mismatched = 0;
  int ref_idx = 0;
  bit ref_tgl = 1'b0;
  int prod_idx = 0;
  bit prod_gen = 1'b1;
  int fill = 0;

  always #2.5 clk = ~clk;

  evq_toggle_reader #(.IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .q_enable(q_enable),
    .req_valid(req_valid), .req_ready(req_ready), .req_peek(req_peek),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_hit(rsp_hit)
  );

  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit is_fresh(int i, bit t);
    return mem[i][31] != t;
  endfunction

  task automatic produce();
    mem[prod_idx] = {prod_gen, 31'($urandom)};
    prod_idx = (prod_idx + 1) % DEPTH;
    if (prod_idx == 0) prod_gen = ~prod_gen;
    fill++;
  endtask

  // Starts and ends just after a falling edge.
  task automatic do_req(bit peek, bit en, int hold, string tag);
    bit fresh;
    logic [30:0] exp_d;
    fresh = en && is_fresh(ref_idx, ref_tgl);
    exp_d = fresh ? mem[ref_idx][30:0] : 31'd0;
    req_valid = 1'b1; req_peek = peek; q_enable = en;
    #0.5;
    chk("R8 ready", {31'd0, req_ready}, 32'd1);
    chk("R7 R8 rd_en", {31'd0, mem_rd_en}, {31'd0, en});
    if (en) chk("R4 R6 addr", {28'd0, mem_addr}, ref_idx);
    @(posedge clk); #0.5;
    req_valid = 1'b0;
    @(negedge clk);
    chk("R8 valid", {31'd0, rsp_valid}, 32'd1);
    chk("R8 busy", {31'd0, req_ready}, 32'd0);
    for (int k = 0; k < hold; k++) begin
      chk("R8 hold", {1'b0, rsp_data}, {1'b0, exp_d});
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    chk({tag, " hit"}, {31'd0, rsp_hit}, {31'd0, fresh});
    chk({tag, " data"}, {1'b0, rsp_data}, {1'b0, exp_d});
    @(posedge clk); #0.5;
    rsp_ready = 1'b0;
    if (fresh && !peek) begin
      ref_idx = (ref_idx + 1) % DEPTH;
      if (ref_idx == 0) ref_tgl = ~ref_tgl;
      fill--;
    end
    q_enable = 1'b1;
    @(negedge clk);
    chk("R8 done", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", {31'd0, req_ready}, 32'd1);
    chk("R1 valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1 addr", {28'd0, mem_addr}, 32'd0);
    do_req(1'b0, 1'b1, 0, "R1");
    // one fresh word: peek twice, disabled read, then consume
    produce();
    do_req(1'b1, 1'b1, 2, "R6");
    do_req(1'b1, 1'b1, 0, "R6");
    do_req(1'b0, 1'b0, 1, "R7");
    do_req(1'b0, 1'b1, 3, "R2");
    do_req(1'b0, 1'b1, 0, "R3");
    // run to the ring end and over it
    for (int i = 0; i < DEPTH - 2; i++) produce();
    for (int i = 0; i < DEPTH - 2; i++) do_req(1'b0, 1'b1, 0, "R4");
    produce();
    do_req(1'b0, 1'b1, 0, "R5");
    chk("R5 wrap", ref_idx, 32'd0);
    do_req(1'b0, 1'b1, 0, "R5");
    // random mix
    for (int n = 0; n < 400; n++) begin
      int act;
      act = $urandom_range(0, 4);
      if (act == 0 && fill < DEPTH - 1) produce();
      else if (act == 1) do_req(1'b1, 1'b1, $urandom_range(0, 2), "R6");
      else if (act == 2) do_req(1'b0, $urandom_range(0, 7) != 0, 0, "R2");
      else do_req(1'b0, 1'b1, $urandom_range(0, 2), "R4");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule